// File: doc/BRIEF.md
# Multi-format serial audio transmitter

This block turns parallel stereo PCM samples into a serial audio bit stream. An external master supplies the bit clock and the frame clock. The block samples both with its own system clock, finds their edges, and drives a single data line. A 24-bit signed left/right pair enters through a ready/valid handshake. The block takes one pair per frame, just before the first bit slot of the left word. If no pair is offered at that point, the previous pair is sent again.

Four framings are supported: right-justified, left-justified, I2S and a DSP pulse mode. A single polarity bit has two meanings. Outside DSP it swaps which frame-clock level means left. In DSP it chooses early or late data placement. A separate bit chooses which bit-clock edge the receiver samples on. The word length can be 16, 20, 24 or 32 bit slots. The block measures the length of each frame segment (a half frame, or the whole frame in DSP) from the frame clock. It uses that length to place the first slot of the next segment and to align right-justified words.

Top module: `pcm_serial_tx`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `sdata` is 0 and `s_ready` is 0.
- R2: With `fmt_sel` = 01 (left-justified), the word's MSB sits in the first slot of its segment and the following bits come one per slot, MSB first.
- R3: With `fmt_sel` = 10 (I2S, the reset encoding), the MSB sits in the second slot of the segment and the first slot is 0.
- R4: With `fmt_sel` = 00 (right-justified), the word's LSB sits in the last slot before the frame clock changes level. The `wlen_sel` code 11 sends 24-bit words in this format.
- R5: With `fmt_sel` = 11 (DSP), a frame starts at the first sampling edge that sees the frame clock high after low. The left word is followed directly by the right word. It starts in that first slot when `pol_sel` = 0 (early) and one slot later when `pol_sel` = 1 (late).
- R6: Outside DSP, `pol_sel` = 0 makes frame-clock low the left half and `pol_sel` = 1 makes frame-clock high the left half.
- R7: With `bclk_inv` = 0, the frame clock is sampled on bit-clock rising edges and `sdata` changes only after falling edges. With `bclk_inv` = 1 the two edges swap.
- R8: `wlen_sel` 00/01/10/11 gives 16/20/24/32 slots. Shorter words carry the top bits of the 24-bit sample. A 32-slot word carries the 24 sample bits and then 8 zeros.
- R9: Every slot outside the active word is driven 0.
- R10: `s_ready` is a one-cycle pulse once per frame, just before the first left-word slot. A pair offered with `s_valid` at that pulse is sent in the next frame. Without it, the last pair is repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_i | input | 1 | External bit clock |
| fclk_i | input | 1 | External frame clock |
| fmt_sel | input | 2 | Framing: 00 right-justified, 01 left-justified, 10 I2S, 11 DSP |
| pol_sel | input | 1 | Left/right level swap outside DSP; early (0) or late (1) in DSP |
| bclk_inv | input | 1 | Swaps the sampling and launch edges of the bit clock |
| wlen_sel | input | 2 | Word slots: 00 16, 01 20, 10 24, 11 32 |
| s_valid | input | 1 | A stereo pair is offered |
| s_left | input | 24 | Left sample, two's complement |
| s_right | input | 24 | Right sample, two's complement |
| s_ready | output | 1 | One-cycle pulse at which a pair is taken |
| sdata | output | 1 | Serial data line |

## Verification
A bit-clock edge reaches `sdata` at the third system-clock rising edge after it arrives: two synchroniser stages, then the output register. The bench drives bit-clock half periods of six system clocks and compares `sdata` with its frame model one system clock before each sampling edge, when the bit is settled. `s_ready` rises three system clocks after the sampling edge of a frame's last slot. The bench counts handshakes at the falling system-clock edge and checks at each frame start that exactly one pair (or none, while the feed is held off) has been taken. The first two frames after each configuration change are not checked. During them the block relearns the segment length it needs for predicting slot positions.

// File: rtl/stx_pkg.sv
// Shared types and helpers for the serial audio transmitter.
// Assumes: the format code values are fixed by the control word layout.
package stx_pkg;

    typedef enum logic [1:0] {
        FMT_RJ  = 2'b00,
        FMT_LJ  = 2'b01,
        FMT_I2S = 2'b10,
        FMT_DSP = 2'b11
    } fmt_e;

    // Number of bit slots the word occupies; 32 is clamped to 24 when right-justified.
    function automatic int word_slots(input logic [1:0] wl, input fmt_e f);
        case (wl)
            2'b00:   return 16;
            2'b01:   return 20;
            2'b10:   return 24;
            default: return (f == FMT_RJ) ? 24 : 32;
        endcase
    endfunction

endpackage

// File: rtl/stx_edge_sync.sv
// Brings the external bit and frame clocks into the system clock domain and
// turns bit-clock transitions into one-cycle sample and launch strobes.
// Assumes: each bit-clock half period spans at least three system clocks and
// the frame clock is stable around the sampling edge.
module stx_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic fclk_i,
    input  logic bclk_inv,
    output logic smp_edge,
    output logic lch_edge,
    output logic fclk_lvl
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] b_sync;
    logic [TOP:0] f_sync;
    logic         b_last;
    logic         b_rise;
    logic         b_fall;

    // Shift both external clocks through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_sync <= '0;
            f_sync <= '0;
            b_last <= 1'b0;
        end else begin
            b_sync <= {b_sync[TOP-1:0], bclk_i};
            f_sync <= {f_sync[TOP-1:0], fclk_i};
            b_last <= b_sync[TOP];
        end
    end

    // Pick sampling and launch strobes from the bit-clock transitions.
    always_comb begin
        b_rise   = b_sync[TOP] & ~b_last;
        b_fall   = ~b_sync[TOP] & b_last;
        smp_edge = bclk_inv ? b_fall : b_rise;
        lch_edge = bclk_inv ? b_rise : b_fall;
        fclk_lvl = f_sync[TOP];
    end

endmodule

// File: rtl/stx_slot_track.sv
// Follows the slot position within each frame segment (a half frame, or a
// whole frame in DSP), measures the segment length, and predicts which
// slot the next launch edge must drive.
// Assumes: segment length stays constant between frames; after a change,
// one full segment is needed before the prediction is right again.
module stx_slot_track #(
    parameter int SLOT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_edge,
    input  logic              fclk_lvl,
    input  logic              is_dsp,
    input  logic              pol_sel,
    output logic [SLOT_W-1:0] nxt_pos,
    output logic              nxt_left,
    output logic [SLOT_W-1:0] seg_len,
    output logic              turn
);
    localparam logic [SLOT_W-1:0] CNT_MAX = '1;
    localparam logic [SLOT_W-1:0] ONE     = 1;
    localparam logic [SLOT_W:0]   ONE_X   = 1;

    logic              prev_lvl;
    logic              seen;
    logic [SLOT_W-1:0] cnt;
    logic [SLOT_W-1:0] seg_len_q;
    logic              cur_left_q;
    logic [SLOT_W-1:0] nxt_pos_q;
    logic              nxt_left_q;
    logic              turn_q;

    logic              start;
    logic [SLOT_W-1:0] pos_now;
    logic [SLOT_W-1:0] pos_inc;
    logic              left_now;
    logic              wrap;

    // Find segment starts and the position of the slot being sampled now.
    always_comb begin
        start    = is_dsp ? (fclk_lvl & ~prev_lvl) : (fclk_lvl ^ prev_lvl);
        pos_inc  = (cnt == CNT_MAX) ? cnt : cnt + ONE;
        pos_now  = start ? '0 : pos_inc;
        left_now = start ? (is_dsp | (fclk_lvl == pol_sel)) : cur_left_q;
        wrap     = (seg_len_q != '0) &&
                   (({1'b0, pos_now} + ONE_X) == {1'b0, seg_len_q});
    end

    // Update position, measured length and next-slot prediction per sampling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lvl   <= 1'b0;
            seen       <= 1'b0;
            cnt        <= '0;
            seg_len_q  <= '0;
            cur_left_q <= 1'b1;
            nxt_pos_q  <= '0;
            nxt_left_q <= 1'b1;
            turn_q     <= 1'b0;
        end else if (smp_edge) begin
            prev_lvl   <= fclk_lvl;
            cnt        <= pos_now;
            cur_left_q <= left_now;
            if (start) begin
                seen <= 1'b1;
                if (seen) begin
                    seg_len_q <= pos_inc;
                end
            end
            nxt_pos_q  <= wrap ? '0 : ((pos_now == CNT_MAX) ? pos_now : pos_now + ONE);
            nxt_left_q <= wrap ? ~left_now : left_now;
            turn_q     <= wrap & (is_dsp | ~left_now);
        end else begin
            turn_q <= 1'b0;
        end
    end

    assign nxt_pos  = nxt_pos_q;
    assign nxt_left = nxt_left_q;
    assign seg_len  = seg_len_q;
    assign turn     = turn_q;

endmodule

// File: rtl/stx_pair_hold.sv
// Holds the stereo pair being serialised and takes a new one at each frame turn.
// Assumes: the turn strobe lasts one cycle and comes before the first left slot is launched.
module stx_pair_hold #(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                turn,
    input  logic                s_valid,
    input  logic [SAMPLE_W-1:0] s_left,
    input  logic [SAMPLE_W-1:0] s_right,
    output logic                s_ready,
    output logic [SAMPLE_W-1:0] act_l,
    output logic [SAMPLE_W-1:0] act_r
);
    assign s_ready = turn;

    // Take the offered pair at a turn; otherwise keep repeating the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_l <= '0;
            act_r <= '0;
        end else if (s_ready && s_valid) begin
            act_l <= s_left;
            act_r <= s_right;
        end
    end

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready); // R10

endmodule

// File: rtl/stx_bit_sel.sv
// Chooses the bit for the predicted next slot from the framing, word length
// and held pair, and registers it onto the data line at each launch edge.
// Assumes: next-slot information settles between a sampling edge and the
// following launch edge.
module stx_bit_sel
    import stx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int SLOT_W   = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lch_edge,
    input  fmt_e                fmt,
    input  logic                late,
    input  logic [1:0]          wlen_sel,
    input  logic [SLOT_W-1:0]   nxt_pos,
    input  logic                nxt_left,
    input  logic [SLOT_W-1:0]   seg_len,
    input  logic [SAMPLE_W-1:0] act_l,
    input  logic [SAMPLE_W-1:0] act_r,
    output logic                sdata
);
    int                  w_slots;
    int                  idx;
    int                  d_pos;
    logic [SAMPLE_W-1:0] word;
    logic [SAMPLE_W-1:0] shifted;
    logic                in_word;
    logic                bit_nx;
    logic                sd_q;

    // Map the predicted slot to a bit index within the left or right word.
    always_comb begin
        w_slots = word_slots(wlen_sel, fmt);
        word    = nxt_left ? act_l : act_r;
        d_pos   = int'(nxt_pos) - int'(late);
        case (fmt)
            FMT_LJ:  idx = int'(nxt_pos);
            FMT_I2S: idx = int'(nxt_pos) - 1;
            FMT_RJ:  idx = int'(nxt_pos) - (int'(seg_len) - w_slots);
            default: begin
                if (d_pos < w_slots) begin
                    word = act_l;
                    idx  = d_pos;
                end else begin
                    word = act_r;
                    idx  = d_pos - w_slots;
                end
            end
        endcase
        in_word = (idx >= 0) && (idx < w_slots) && (idx < SAMPLE_W);
        shifted = in_word ? (word << idx) : '0;
        bit_nx  = shifted[SAMPLE_W-1];
    end

    // Drive the data line only at launch edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_q <= 1'b0;
        end else if (lch_edge) begin
            sd_q <= bit_nx;
        end
    end

    assign sdata = sd_q;

    AST_RJ_WORD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == FMT_RJ) |-> (w_slots <= 24)); // R4

endmodule

// File: rtl/pcm_serial_tx.sv
// Multi-format serial audio transmitter. Samples externally supplied bit and
// frame clocks, follows the frame structure, and shifts held stereo pairs
// onto the data line MSB first in the selected framing.
// Assumes: system clock at least six times the bit-clock rate; control inputs
// change only between frames.
module pcm_serial_tx
    import stx_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int SLOT_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_i,
    input  logic                fclk_i,
    input  logic [1:0]          fmt_sel,
    input  logic                pol_sel,
    input  logic                bclk_inv,
    input  logic [1:0]          wlen_sel,
    input  logic                s_valid,
    input  logic [SAMPLE_W-1:0] s_left,
    input  logic [SAMPLE_W-1:0] s_right,
    output logic                s_ready,
    output logic                sdata
);
    fmt_e                fmt;
    logic                is_dsp;
    logic                smp_edge;
    logic                lch_edge;
    logic                fclk_lvl;
    logic [SLOT_W-1:0]   nxt_pos;
    logic                nxt_left;
    logic [SLOT_W-1:0]   seg_len;
    logic                turn;
    logic [SAMPLE_W-1:0] act_l;
    logic [SAMPLE_W-1:0] act_r;

    assign fmt    = fmt_e'(fmt_sel);
    assign is_dsp = (fmt == FMT_DSP);

    stx_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_i   (bclk_i),
        .fclk_i   (fclk_i),
        .bclk_inv (bclk_inv),
        .smp_edge (smp_edge),
        .lch_edge (lch_edge),
        .fclk_lvl (fclk_lvl)
    );

    stx_slot_track #(.SLOT_W(SLOT_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_edge (smp_edge),
        .fclk_lvl (fclk_lvl),
        .is_dsp   (is_dsp),
        .pol_sel  (pol_sel),
        .nxt_pos  (nxt_pos),
        .nxt_left (nxt_left),
        .seg_len  (seg_len),
        .turn     (turn)
    );

    stx_pair_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .turn    (turn),
        .s_valid (s_valid),
        .s_left  (s_left),
        .s_right (s_right),
        .s_ready (s_ready),
        .act_l   (act_l),
        .act_r   (act_r)
    );

    stx_bit_sel #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .lch_edge (lch_edge),
        .fmt      (fmt),
        .late     (pol_sel),
        .wlen_sel (wlen_sel),
        .nxt_pos  (nxt_pos),
        .nxt_left (nxt_left),
        .seg_len  (seg_len),
        .act_l    (act_l),
        .act_r    (act_r),
        .sdata    (sdata)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (sdata == 1'b0 && s_ready == 1'b0)); // R1

    AST_DATA_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        !lch_edge |=> $stable(sdata)); // R7

    AST_READY_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> $past(smp_edge)); // R10

endmodule

// File: tb/pcm_serial_tx_test.sv
// Self-checking bench: drives bit/frame clocks as a master, builds each
// frame's expected bit sequence in a queue, and compares it slot by slot.
module pcm_serial_tx_test;

    localparam int HP    = 6;   // system clocks per bit-clock half period
    localparam int HALF  = 32;  // slots per half frame
    localparam int NPAIR = 120;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_i = 1'b0;
    logic        fclk_i = 1'b0;
    logic [1:0]  fmt_sel = 2'b10;
    logic        pol_sel = 1'b0;
    logic        bclk_inv = 1'b0;
    logic [1:0]  wlen_sel = 2'b10;
    logic        s_valid = 1'b0;
    logic [23:0] s_left = '0;
    logic [23:0] s_right = '0;
    logic        s_ready;
    logic        sdata;

    int          checks = 0;
    int          errors = 0;
    int          acc_cnt = 0;
    bit          feed_en = 1'b1;
    bit          done = 1'b0;
    logic [23:0] last_l = '0;
    logic [23:0] last_r = '0;
    logic [23:0] pend_l[$];
    logic [23:0] pend_r[$];
    bit          exp_q[$];

    always #2 clk = ~clk;

    pcm_serial_tx uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_i   (bclk_i),
        .fclk_i   (fclk_i),
        .fmt_sel  (fmt_sel),
        .pol_sel  (pol_sel),
        .bclk_inv (bclk_inv),
        .wlen_sel (wlen_sel),
        .s_valid  (s_valid),
        .s_left   (s_left),
        .s_right  (s_right),
        .s_ready  (s_ready),
        .sdata    (sdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Feeder: offers the queue head and records every completed handshake.
    initial begin
        for (int n = 0; n < NPAIR; n++) begin
            pend_l.push_back(24'(32'h5A3C71 + n * 32'h01F2D3));
            pend_r.push_back(24'(32'hA1B2C3 ^ (n * 32'h00E4F9)));
        end
        forever begin
            @(negedge clk);
            if (s_valid && s_ready) begin
                last_l = pend_l.pop_front();
                last_r = pend_r.pop_front();
                acc_cnt++;
                @(posedge clk);
                #1;
                s_valid = 1'b0;
            end else if (!s_ready) begin
                s_valid = feed_en && (pend_l.size() > 0);
                if (pend_l.size() > 0) begin
                    s_left  = pend_l[0];
                    s_right = pend_r[0];
                end
            end
        end
    end

    // Expected slot bits of one whole frame, from the requirement rules.
    function automatic void build_frame();
        int w;
        int lead;
        exp_q.delete();
        case (wlen_sel)
            2'b00: w = 16;
            2'b01: w = 20;
            2'b10: w = 24;
            default: w = (fmt_sel == 2'b00) ? 24 : 32;
        endcase
        if (fmt_sel == 2'b11) begin
            for (int s = 0; s < 2 * HALF; s++) begin
                int d = s - int'(pol_sel);
                if (d >= 0 && d < w) exp_q.push_back((d < 24) ? last_l[23 - d] : 1'b0);
                else if (d >= w && d < 2 * w)
                    exp_q.push_back((d - w < 24) ? last_r[23 - (d - w)] : 1'b0);
                else exp_q.push_back(1'b0);
            end
        end else begin
            lead = (fmt_sel == 2'b01) ? 0 : (fmt_sel == 2'b10) ? 1 : HALF - w;
            for (int h = 0; h < 2; h++) begin
                for (int k = 0; k < HALF; k++) begin
                    int i = k - lead;
                    logic [23:0] wd = (h == 0) ? last_l : last_r;
                    exp_q.push_back((i >= 0 && i < w && i < 24) ? wd[23 - i] : 1'b0);
                end
            end
        end
    endfunction

    // One frame of master clocking; optionally compares every slot.
    task automatic run_frame(input bit check, input string tag);
        for (int s = 0; s < 2 * HALF; s++) begin
            if (s == 0) begin
                if (check) begin
                    if (feed_en) chk(acc_cnt == 1, "R10", "pairs taken per frame", acc_cnt, 1);
                    else         chk(acc_cnt == 0, "R10", "pairs taken while idle", acc_cnt, 0);
                end
                acc_cnt = 0;
                build_frame();
            end
            bclk_i = bclk_inv;
            if (fmt_sel == 2'b11) fclk_i = (s == 0);
            else                  fclk_i = (s < HALF) ? pol_sel : ~pol_sel;
            repeat (HP - 1) @(negedge clk);
            if (check)
                chk(sdata == exp_q[s], tag, $sformatf("slot %0d data", s),
                    int'(sdata), int'(exp_q[s]));
            @(negedge clk);
            bclk_i = ~bclk_inv;
            repeat (HP) @(negedge clk);
        end
    endtask

    task automatic run_cfg(input logic [1:0] f, input logic p, input logic inv,
                           input logic [1:0] wl, input string tag);
        fmt_sel  = f;
        pol_sel  = p;
        bclk_inv = inv;
        wlen_sel = wl;
        run_frame(1'b0, tag);
        run_frame(1'b0, tag);
        run_frame(1'b1, tag);
        run_frame(1'b1, tag);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(sdata == 1'b0, "R1", "sdata in reset", int'(sdata), 0);
        chk(s_ready == 1'b0, "R1", "s_ready in reset", int'(s_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sdata == 1'b0, "R1", "sdata after reset", int'(sdata), 0);
        chk(s_ready == 1'b0, "R1", "s_ready after reset", int'(s_ready), 0);

        run_cfg(2'b10, 1'b0, 1'b0, 2'b10, "R3 R9 i2s 24");
        run_cfg(2'b01, 1'b0, 1'b0, 2'b10, "R2 R9 left-justified 24");
        run_cfg(2'b00, 1'b0, 1'b0, 2'b10, "R4 R9 right-justified 24");
        run_cfg(2'b00, 1'b0, 1'b0, 2'b11, "R4 right-justified 32 clamp");
        run_cfg(2'b01, 1'b0, 1'b0, 2'b00, "R8 left-justified 16");
        run_cfg(2'b10, 1'b0, 1'b0, 2'b01, "R8 i2s 20");
        run_cfg(2'b01, 1'b0, 1'b0, 2'b11, "R8 left-justified 32");
        run_cfg(2'b00, 1'b0, 1'b0, 2'b00, "R4 R8 right-justified 16");
        run_cfg(2'b10, 1'b1, 1'b0, 2'b10, "R6 i2s swapped levels");
        run_cfg(2'b01, 1'b1, 1'b0, 2'b01, "R6 left-justified swapped levels");
        run_cfg(2'b01, 1'b0, 1'b1, 2'b10, "R7 inverted bit clock");
        run_cfg(2'b00, 1'b1, 1'b1, 2'b10, "R7 R6 inverted clock rj");
        run_cfg(2'b11, 1'b0, 1'b0, 2'b10, "R5 dsp early 24");
        run_cfg(2'b11, 1'b1, 1'b0, 2'b10, "R5 dsp late 24");
        run_cfg(2'b11, 1'b0, 1'b0, 2'b11, "R5 R8 dsp early 32");
        run_cfg(2'b11, 1'b1, 1'b1, 2'b00, "R5 R7 dsp late 16");

        // R10: no pair offered, so the last pair repeats and nothing is taken.
        fmt_sel  = 2'b10;
        pol_sel  = 1'b0;
        bclk_inv = 1'b0;
        wlen_sel = 2'b10;
        run_frame(1'b0, "R10");
        run_frame(1'b0, "R10");
        feed_en = 1'b0;
        run_frame(1'b0, "R10");
        run_frame(1'b1, "R10 repeated pair");
        run_frame(1'b1, "R10 repeated pair");
        feed_en = 1'b1;
        run_frame(1'b0, "R10");
        run_frame(1'b1, "R10 feed resumed");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule